// File: doc/BRIEF.md
# Restoring Sequential Divider with Early Overflow Abort

This block divides a double-length unsigned magnitude by a single-length magnitude. The dividend arrives as a high half and a low half, each `W` bits wide. The divisor is `W` bits wide. Each operand also carries a sign bit, so the data is in signed-magnitude form. The block returns a `W`-bit quotient magnitude, a `W`-bit remainder magnitude, and a sign for each.

A rising edge on which `start` is high in the idle state captures the operands. In the next cycle the block makes one trial subtraction of the divisor from the dividend high half. If the high half is not below the divisor, the quotient cannot fit in `W` bits. The block then raises the overflow flag, pulses `done` and forms no quotient.

Otherwise the block runs `W` shift-and-subtract steps. Each step forms one quotient bit. The trial subtraction adds the two's complement of the divisor, and the carry out shows whether the shifted partial remainder reached the divisor. When the trial fails, the partial remainder before the trial is kept, which restores it. When the bit shifted out of the top of the partial remainder is 1, the step always subtracts, whatever the carry.

Top module: `rdiv_core`

## Requirements
- R1: After reset, `quo`, `rem`, `quo_neg`, `rem_neg`, `ovf` and `done` are all 0.
- R2: When the captured `dvd_hi` is greater than or equal to `dvs`, `ovf` is 1 when `done` pulses. This includes a zero divisor and the case where `dvd_hi` equals `dvs`.
- R3: On an overflow completion, `quo`, `rem`, `quo_neg` and `rem_neg` keep the values of the previous completed division (0 after reset).
- R4: When `dvd_hi` < `dvs`, the completion gives `ovf` = 0. It also gives `quo` = floor({`dvd_hi`,`dvd_lo`} / `dvs`) and `rem` = {`dvd_hi`,`dvd_lo`} mod `dvs`, with `rem` < `dvs`.
- R5: On a normal completion, `quo_neg` equals `dvd_neg` XOR `dvs_neg`.
- R6: On a normal completion, `rem_neg` equals `dvd_neg`, including when the remainder is zero.
- R7: A normal division raises `done` on the (W+1)th rising edge after the edge that captured `start`. An overflow raises `done` on the first rising edge after it.
- R8: `done` is high for exactly one cycle per accepted start. All outputs hold their values between completions.
- R9: A `start` that arrives while a division is in progress has no effect. The running division completes with its own operands, and no extra completion follows.
- R10: When the shifted partial remainder has 1 in its shifted-out top bit, the step takes the subtraction and sets the quotient bit. Results stay correct for divisors with the top bit set, and the partial remainder stays below the divisor throughout the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; sampled only when idle |
| dvd_hi | input | W | Upper half of dividend magnitude |
| dvd_lo | input | W | Lower half of dividend magnitude |
| dvd_neg | input | 1 | Dividend sign, 1 = negative |
| dvs | input | W | Divisor magnitude |
| dvs_neg | input | 1 | Divisor sign, 1 = negative |
| quo | output | W | Quotient magnitude |
| rem | output | W | Remainder magnitude |
| quo_neg | output | 1 | Quotient sign |
| rem_neg | output | 1 | Remainder sign |
| ovf | output | 1 | Divide overflow seen on the last completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
The division is driven with small values and a range of remainders, and with all four sign combinations. These cases separate the magnitude path from the sign path. Dividends whose high half equals the divisor, or lies just below it, test the overflow compare at its boundary. A zero divisor and a zero dividend test the two degenerate ends. A divisor of all ones with the largest legal dividend forces the shifted-out top bit to decide quotient bits, which a carry-only design gets wrong. A stream of generated operands checks latency and values, and a start pulsed mid-division shows that requests arriving while busy are discarded.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    localparam int RDIV_W_DEFAULT = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ITER  = 2'd2
    } rdiv_state_e;

    typedef struct packed {
        logic quo;
        logic rem;
    } rdiv_sign_t;

    typedef struct packed {
        logic dvd;
        logic dvs;
    } rdiv_opsign_t;

    function automatic rdiv_sign_t result_signs(rdiv_opsign_t s);
        rdiv_sign_t r;
        r.quo = s.dvd ^ s.dvs;
        r.rem = s.dvd;
        return r;
    endfunction

endpackage

// File: rtl/rdiv_trial_sub.sv
module rdiv_trial_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] minu,
    input  logic [W-1:0] subt,
    output logic [W-1:0] diff,
    output logic         carry
);
    logic [W:0] sum;

    always_comb begin
        sum   = {1'b0, minu} + {1'b0, ~subt} + (W+1)'(1);
        diff  = sum[W-1:0];
        carry = sum[W];
    end
endmodule

// File: rtl/rdiv_step.sv
module rdiv_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_cur,
    input  logic [W-1:0] q_cur,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] a_nxt,
    output logic [W-1:0] q_nxt
);
    logic         e_out;
    logic [W-1:0] a_sh;
    logic [W-1:0] diff;
    logic         carry;
    logic         take;

    always_comb begin
        e_out = a_cur[W-1];
        a_sh  = {a_cur[W-2:0], q_cur[W-1]};
    end

    rdiv_trial_sub #(.W(W)) u_sub (
        .minu  (a_sh),
        .subt  (dvs),
        .diff  (diff),
        .carry (carry)
    );

    always_comb begin
        take  = e_out | carry;
        a_nxt = take ? diff : a_sh;
        q_nxt = {q_cur[W-2:0], take};
    end
endmodule

// File: rtl/rdiv_seq.sv
module rdiv_seq
    import rdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ovf_hit,
    output logic ld,
    output logic step_en,
    output logic fin_ok,
    output logic fin_ovf,
    output logic busy,
    output logic iter
);
    localparam int CW = $clog2(W + 1);

    rdiv_state_e   state, state_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        state_nx = state;
        ld       = 1'b0;
        step_en  = 1'b0;
        fin_ok   = 1'b0;
        fin_ovf  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ld       = 1'b1;
                    state_nx = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (ovf_hit) begin
                    fin_ovf  = 1'b1;
                    state_nx = ST_IDLE;
                end else begin
                    state_nx = ST_ITER;
                end
            end
            ST_ITER: begin
                step_en = 1'b1;
                if (cnt == CW'(1)) begin
                    fin_ok   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CHECK)
                cnt <= CW'(W);
            else if (step_en)
                cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        iter = (state == ST_ITER);
    end
endmodule

// File: rtl/rdiv_core.sv
module rdiv_core
    import rdiv_pkg::*;
#(
    parameter int W = RDIV_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic         dvd_neg,
    input  logic [W-1:0] dvs,
    input  logic         dvs_neg,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         quo_neg,
    output logic         rem_neg,
    output logic         ovf,
    output logic         done
);
    logic [W-1:0] a_r, q_r, b_r;
    rdiv_opsign_t opsign_r;
    rdiv_sign_t   outsign_r;
    logic [W-1:0] a_nx, q_nx;
    logic [W-1:0] chk_diff;
    logic         chk_carry;
    logic         ld, step_en, fin_ok, fin_ovf, busy, iter;

    // overflow probe: high half minus divisor, carry set means high >= divisor
    rdiv_trial_sub #(.W(W)) u_ovf (
        .minu  (a_r),
        .subt  (b_r),
        .diff  (chk_diff),
        .carry (chk_carry)
    );

    rdiv_step #(.W(W)) u_step (
        .a_cur (a_r),
        .q_cur (q_r),
        .dvs   (b_r),
        .a_nxt (a_nx),
        .q_nxt (q_nx)
    );

    rdiv_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ovf_hit (chk_carry),
        .ld      (ld),
        .step_en (step_en),
        .fin_ok  (fin_ok),
        .fin_ovf (fin_ovf),
        .busy    (busy),
        .iter    (iter)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r       <= '0;
            q_r       <= '0;
            b_r       <= '0;
            opsign_r  <= '0;
            outsign_r <= '0;
            quo       <= '0;
            rem       <= '0;
            ovf       <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= fin_ok | fin_ovf;
            if (ld) begin
                a_r          <= dvd_hi;
                q_r          <= dvd_lo;
                b_r          <= dvs;
                opsign_r.dvd <= dvd_neg;
                opsign_r.dvs <= dvs_neg;
            end else if (step_en) begin
                a_r <= a_nx;
                q_r <= q_nx;
            end
            if (fin_ok) begin
                quo       <= q_nx;
                rem       <= a_nx;
                outsign_r <= result_signs(opsign_r);
                ovf       <= 1'b0;
            end else if (fin_ovf) begin
                ovf <= 1'b1;
            end
        end
    end

    always_comb begin
        quo_neg = outsign_r.quo;
        rem_neg = outsign_r.rem;
    end

    logic unused_ok;
    always_comb unused_ok = ^chk_diff;
endmodule

// File: rtl/rdiv_props.sv
module rdiv_props #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic         ovf,
    input logic [W-1:0] quo,
    input logic [W-1:0] rem,
    input logic         quo_neg,
    input logic         rem_neg,
    input logic         busy,
    input logic         iter,
    input logic [W-1:0] a_r,
    input logic [W-1:0] b_r
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quo) && $stable(rem) && $stable(quo_neg) && $stable(rem_neg)));

    assert_ovf_keeps_result_R3: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> ($stable(quo) && $stable(rem) && $stable(quo_neg) && $stable(rem_neg)));

    assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !ovf) |-> (rem < b_r));

    assert_partial_below_divisor_R10: assert property (@(posedge clk) disable iff (rst)
        iter |-> (a_r < b_r));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(b_r));
endmodule

bind rdiv_core rdiv_props #(.W(W)) u_props (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .ovf     (ovf),
    .quo     (quo),
    .rem     (rem),
    .quo_neg (quo_neg),
    .rem_neg (rem_neg),
    .busy    (busy),
    .iter    (iter),
    .a_r     (a_r),
    .b_r     (b_r)
);

// File: tb/sim_rdiv_core.sv
`timescale 1ns/1ps
module sim_rdiv_core;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
    logic         dvd_neg = 1'b0, dvs_neg = 1'b0;
    logic [W-1:0] quo, rem;
    logic         quo_neg, rem_neg, ovf, done;

    always #10 clk = ~clk;

    rdiv_core #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvd_neg(dvd_neg),
        .dvs(dvs), .dvs_neg(dvs_neg),
        .quo(quo), .rem(rem), .quo_neg(quo_neg), .rem_neg(rem_neg),
        .ovf(ovf), .done(done)
    );

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         qs;
        logic         rs;
        logic         ov;
        int           lat;
        int           t0;
        string        tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    logic prev_done = 1'b0;
    logic [W-1:0] m_q = '0, m_r = '0;
    logic         m_qs = 1'b0, m_rs = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop and compare on each completion
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done)
                chk(done == 1'b0, "R8 done single pulse", done, 0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(ovf == e.ov, {e.tag, " R2 ovf"}, ovf, e.ov);
                    chk(quo == e.q, {e.tag, (e.ov ? " R3 quo held" : " R4 quo")}, quo, e.q);
                    chk(rem == e.r, {e.tag, (e.ov ? " R3 rem held" : " R4 rem")}, rem, e.r);
                    chk(quo_neg == e.qs, {e.tag, (e.ov ? " R3 sign held" : " R5 quo sign")}, quo_neg, e.qs);
                    chk(rem_neg == e.rs, {e.tag, (e.ov ? " R3 sign held" : " R6 rem sign")}, rem_neg, e.rs);
                    chk((cyc - e.t0) == e.lat, {e.tag, " R7 latency"}, cyc - e.t0, e.lat);
                end
            end
            prev_done = done;
        end
    end

    task automatic issue(input string tag, input logic [W-1:0] hi, input logic [W-1:0] lo,
                         input logic sn, input logic [W-1:0] dv, input logic sd, input bit poke);
        exp_t e;
        logic [2*W-1:0] n;
        n = {hi, lo};
        e.tag = tag;
        if (hi >= dv) begin
            e.ov = 1'b1; e.q = m_q; e.r = m_r; e.qs = m_qs; e.rs = m_rs; e.lat = 1;
        end else begin
            e.ov = 1'b0;
            e.q  = W'(n / {{W{1'b0}}, dv});
            e.r  = W'(n % {{W{1'b0}}, dv});
            e.qs = sn ^ sd;
            e.rs = sn;
            e.lat = W + 1;
            m_q = e.q; m_r = e.r; m_qs = e.qs; m_rs = e.rs;
        end
        @(negedge clk);
        dvd_hi = hi; dvd_lo = lo; dvd_neg = sn; dvs = dv; dvs_neg = sd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.t0 = cyc;
        sb_q.push_back(e);
        if (poke) begin
            // R9: a request while busy, with operands that would differ
            dvd_hi = '0; dvd_lo = 8'h55; dvs = 8'h03; dvd_neg = ~sn; dvs_neg = ~sd;
            start = 1'b1;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(quo == '0 && rem == '0, "R1 reset result", {quo, rem}, 0);
        chk(quo_neg == 1'b0 && rem_neg == 1'b0, "R1 reset signs", {quo_neg, rem_neg}, 0);
        chk(ovf == 1'b0 && done == 1'b0, "R1 reset flags", {ovf, done}, 0);

        issue("ovf_first", 8'h04, 8'h00, 1'b1, 8'h04, 1'b0, 1'b0);   // R2 equal, R3 held at zero
        issue("basic", 8'h03, 8'hE8, 1'b0, 8'h07, 1'b0, 1'b0);       // R4
        issue("neg_pos", 8'h00, 8'h64, 1'b1, 8'h03, 1'b0, 1'b0);     // R5 R6
        issue("pos_neg", 8'h01, 8'h2C, 1'b0, 8'h09, 1'b1, 1'b0);     // R5
        issue("neg_neg", 8'h00, 8'h51, 1'b1, 8'h09, 1'b1, 1'b0);     // R6 zero remainder
        issue("ovf_eq", 8'h05, 8'h10, 1'b1, 8'h05, 1'b1, 1'b0);      // R2 R3
        issue("ovf_zero_div", 8'h00, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0); // R2
        issue("ovf_above", 8'hF0, 8'h00, 1'b0, 8'h10, 1'b1, 1'b0);   // R2 R3
        issue("topbit_R10", 8'hFE, 8'hFF, 1'b0, 8'hFF, 1'b0, 1'b0);
        issue("topbit2_R10", 8'h80, 8'h01, 1'b1, 8'hC3, 1'b0, 1'b0);
        issue("edge_below", 8'h09, 8'hFF, 1'b0, 8'h0A, 1'b0, 1'b0);  // R2 boundary, R4
        issue("zero_dvd", 8'h00, 8'h00, 1'b1, 8'h09, 1'b0, 1'b0);    // R4 R6
        issue("busy_R9", 8'h12, 8'h34, 1'b0, 8'h56, 1'b1, 1'b1);
        lf = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] dv, hi;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            dv = lf[7:0] | 8'h01;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            hi = (i % 5 == 4) ? dv + W'(lf[1:0]) : W'(lf[15:8] % dv);
            if (i % 5 == 4 && hi < dv) hi = dv;
            issue("stream", hi, lf[7:0], lf[3], dv, lf[9], 1'b0);
        end
        repeat (W + 4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule